// File: doc/BRIEF.md
# SIMD Warp Issue Scheduler

This block is the issue stage of a streaming multiprocessor core. A warp is a group of 32 threads that all run the same instruction. The datapath has only 8 lanes, so each warp instruction goes out as four back-to-back beats. On each beat the scheduler presents the warp id, the beat index, the 8-bit lane enable slice and the warp's program counter. It holds a PC for each of 24 hardware warp contexts.

Each cycle the scheduler samples a ready bit and a 32-bit active-thread mask for every warp. A new warp is chosen only at a beat boundary: when nothing is in flight, or on the fourth beat of the current instruction. The choice is round-robin among warps that are both ready and have at least one active thread. Once a warp is chosen it keeps all four beats. Its active mask is captured at that moment, and the warp's PC moves on by 4 when the last beat leaves.

A ready warp whose mask is all zeros takes no beats. At a boundary its PC is stepped past the instruction instead. Threads that are masked off inside a non-empty warp still use their beat slots with their lane enables cleared.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset is released, `issue_valid_o` is low and every warp PC holds `RESET_PC` (0 by default). Search order starts at warp 0.
- R2: A chosen warp issues on four consecutive cycles with `issue_beat_o` = 0, 1, 2, 3 and an unchanged `issue_warp_o`. This holds even if its ready bit or mask drops in the meantime.
- R3: On beat k, `issue_lanes_o` equals bits [8k+7:8k] of the warp's mask as captured in the cycle the warp was chosen. Bit i of the slice enables lane i. Mask changes after that cycle have no effect on the slices.
- R4: A selection slot is a cycle where no warp is in flight or beat 3 is issuing. In a selection slot, the next warp is the first eligible warp (ready bit set, mask non-zero) in ascending index order after the last granted warp, wrapping from 23 to 0. The same warp may be granted again.
- R5: A warp's PC increases by 4 on the clock edge that ends its beat 3, so its next issue shows the old PC plus 4.
- R6: In every selection slot, each warp that is ready with an all-zero mask has its PC increased by 4 and is given no beats. A PC never increases by more than 4 in one cycle.
- R7: If no warp is eligible in a selection slot, `issue_valid_o` is low in the next cycle and `issue_lanes_o` is all zero while it stays low.
- R8: While `issue_valid_o` is high, `issue_pc_o` is the current PC of the warp shown on `issue_warp_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 24 | Ready bit, one per warp |
| mask_i | input | 768 | Active-thread masks; warp w occupies bits [32w+31:32w] |
| issue_valid_o | output | 1 | A beat is being issued this cycle |
| issue_warp_o | output | 5 | Id of the issuing warp |
| issue_beat_o | output | 2 | Beat index 0 to 3 |
| issue_lanes_o | output | 8 | Lane enables for this beat |
| issue_pc_o | output | 32 | PC of the issuing warp |

## Verification
The bench drives long stretches of random ready bits and masks that change every cycle, so masks move during an instruction's flight. A design that slices the live mask instead of the captured one emits wrong lane enables on beats 1 to 3. Phases with sparse ready vectors and with many empty masks check two things. Wrap-around of the round-robin pointer must be right, or the wrong warp id appears. Zero-mask skipping must also be right: a design that issues empty warps, or forgets to step their PC, shows the wrong warp or a PC off by multiples of 4 at the next real issue. A phase where every ready bit drops mid-instruction shows whether the block preempts, and whether it deasserts valid once nothing is eligible.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  parameter int unsigned DEF_WARPS   = 24;
  parameter int unsigned DEF_THREADS = 32;
  parameter int unsigned DEF_LANES   = 8;
  parameter int unsigned DEF_PC_W    = 32;
  parameter int unsigned DEF_PC_STEP = 4;
endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int unsigned N     = 24,
  parameter int unsigned IDX_W = 5
) (
  input  logic [N-1:0]     elig_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan from last+1 upward with wrap
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < int'(N); i++) begin
      int cand;
      cand = (int'(last_i) + 1 + i) % int'(N);
      if (!found_o && elig_i[cand]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/wis_pc_bank.sv
module wis_pc_bank #(
  parameter int unsigned N        = 24,
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PC_STEP  = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    adv_i,
  output logic [N*PC_W-1:0] pc_o
);
  for (genvar w = 0; w < int'(N); w++) begin : g_ctx
    logic [PC_W-1:0] pc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pc_q <= RESET_PC;
      else if (adv_i[w]) pc_q <= pc_q + PC_W'(PC_STEP);
    end
    assign pc_o[w*PC_W +: PC_W] = pc_q;
  end
endmodule

// File: rtl/wis_lane_slice.sv
module wis_lane_slice #(
  parameter int unsigned THREADS = 32,
  parameter int unsigned LANES   = 8,
  parameter int unsigned BEAT_W  = 2
) (
  input  logic [THREADS-1:0] mask_i,
  input  logic [BEAT_W-1:0]  beat_i,
  input  logic               en_i,
  output logic [LANES-1:0]   lanes_o
);
  localparam int unsigned BEATS = THREADS / LANES;
  logic [LANES-1:0] parts [BEATS];
  for (genvar b = 0; b < int'(BEATS); b++) begin : g_part
    assign parts[b] = mask_i[b*LANES +: LANES];
  end
  assign lanes_o = en_i ? parts[beat_i] : '0;
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = DEF_WARPS,
  parameter int unsigned THREADS   = DEF_THREADS,
  parameter int unsigned LANES     = DEF_LANES,
  parameter int unsigned PC_W      = DEF_PC_W,
  parameter int unsigned PC_STEP   = DEF_PC_STEP,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int unsigned BEATS  = THREADS / LANES,
  localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int unsigned WID_W  = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_WARPS-1:0]         ready_i,
  input  logic [NUM_WARPS*THREADS-1:0] mask_i,
  output logic                         issue_valid_o,
  output logic [WID_W-1:0]             issue_warp_o,
  output logic [BEAT_W-1:0]            issue_beat_o,
  output logic [LANES-1:0]             issue_lanes_o,
  output logic [PC_W-1:0]              issue_pc_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic                 busy_q;
  logic [WID_W-1:0]     cur_q, last_q;
  logic [BEAT_W-1:0]    beat_q;
  logic [THREADS-1:0]   mask_q;

  logic                 sel_slot, finish;
  logic [NUM_WARPS-1:0] nz, elig, adv;
  logic                 grant_vld;
  logic [WID_W-1:0]     grant_idx;
  logic [NUM_WARPS*PC_W-1:0] pc_flat;
  logic [PC_W-1:0]      pc_arr [NUM_WARPS];
  logic [THREADS-1:0]   mask_arr [NUM_WARPS];

  assign sel_slot = !busy_q || (beat_q == LAST_BEAT);
  assign finish   = busy_q && (beat_q == LAST_BEAT);

  for (genvar w = 0; w < int'(NUM_WARPS); w++) begin : g_warp
    assign mask_arr[w] = mask_i[w*THREADS +: THREADS];
    assign pc_arr[w]   = pc_flat[w*PC_W +: PC_W];
    assign nz[w]       = |mask_arr[w];
    assign elig[w]     = ready_i[w] && nz[w];
    // empty warp consumes a slot's PC step; finishing warp steps once
    assign adv[w]      = (finish && (cur_q == WID_W'(w))) ||
                         (sel_slot && ready_i[w] && !nz[w]);
  end

  wis_rr_pick #(.N(NUM_WARPS), .IDX_W(WID_W)) u_pick (
    .elig_i  (elig),
    .last_i  (last_q),
    .found_o (grant_vld),
    .idx_o   (grant_idx)
  );

  wis_pc_bank #(.N(NUM_WARPS), .PC_W(PC_W), .PC_STEP(PC_STEP),
                .RESET_PC(RESET_PC)) u_pcs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .pc_o   (pc_flat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      last_q <= WID_W'(NUM_WARPS - 1);
      beat_q <= '0;
      mask_q <= '0;
    end else if (sel_slot) begin
      busy_q <= grant_vld;
      beat_q <= '0;
      if (grant_vld) begin
        cur_q  <= grant_idx;
        last_q <= grant_idx;
        mask_q <= mask_arr[grant_idx];
      end
    end else begin
      beat_q <= beat_q + 1'b1;
    end
  end

  wis_lane_slice #(.THREADS(THREADS), .LANES(LANES), .BEAT_W(BEAT_W)) u_slice (
    .mask_i  (mask_q),
    .beat_i  (beat_q),
    .en_i    (busy_q),
    .lanes_o (issue_lanes_o)
  );

  assign issue_valid_o = busy_q;
  assign issue_warp_o  = cur_q;
  assign issue_beat_o  = beat_q;
  assign issue_pc_o    = pc_arr[cur_q];
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int unsigned NUM_WARPS = 24,
  parameter int unsigned WID_W     = 5,
  parameter int unsigned BEAT_W    = 2,
  parameter int unsigned LANES     = 8,
  parameter int unsigned PC_W      = 32,
  parameter int unsigned BEATS     = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_WARPS-1:0] ready_i,
  input logic                 issue_valid_o,
  input logic [WID_W-1:0]     issue_warp_o,
  input logic [BEAT_W-1:0]    issue_beat_o,
  input logic [LANES-1:0]     issue_lanes_o,
  input logic [PC_W-1:0]      issue_pc_o
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  a_r2_beat_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && issue_beat_o != LAST) |=>
      (issue_valid_o && issue_beat_o == $past(issue_beat_o) + 1'b1 &&
       $stable(issue_warp_o)));

  a_r8_pc_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && issue_beat_o != LAST) |=> $stable(issue_pc_o));

  a_r2_start_beat0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(issue_valid_o) |-> issue_beat_o == '0);

  a_r7_idle_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o |-> issue_lanes_o == '0);

  a_r7_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!issue_valid_o || issue_beat_o == LAST) && ready_i == '0) |=> !issue_valid_o);

  a_r4_warp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> int'(issue_warp_o) < int'(NUM_WARPS));
endmodule

bind warp_issue_sched wis_checker #(
  .NUM_WARPS(NUM_WARPS), .WID_W(WID_W), .BEAT_W(BEAT_W),
  .LANES(LANES), .PC_W(PC_W), .BEATS(BEATS)
) u_wis_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ready_i       (ready_i),
  .issue_valid_o (issue_valid_o),
  .issue_warp_o  (issue_warp_o),
  .issue_beat_o  (issue_beat_o),
  .issue_lanes_o (issue_lanes_o),
  .issue_pc_o    (issue_pc_o)
);

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;
  localparam int NW = 24;
  localparam int TH = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NW-1:0] ready_i = '0;
  logic [NW*TH-1:0] mask_i = '0;
  logic          issue_valid_o;
  logic [4:0]    issue_warp_o;
  logic [1:0]    issue_beat_o;
  logic [7:0]    issue_lanes_o;
  logic [31:0]   issue_pc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_pc [NW];
  bit          m_busy;
  int          m_cur, m_beat, m_last;
  logic [31:0] m_mask;

  always #5 clk_i = ~clk_i;

  warp_issue_sched dut_i (
    .clk_i, .rst_ni, .ready_i, .mask_i,
    .issue_valid_o, .issue_warp_o, .issue_beat_o, .issue_lanes_o, .issue_pc_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mw(int w);
    return mask_i[w*TH +: TH];
  endfunction

  // compare outputs against model, then advance model for the coming edge
  task automatic step();
    bit sel, fin;
    int found;
    @(negedge clk_i);
    chk(issue_valid_o == m_busy, "R1/R7 valid", issue_valid_o, m_busy);
    if (m_busy) begin
      chk(issue_warp_o == m_cur, "R4 warp", issue_warp_o, m_cur);
      chk(issue_beat_o == m_beat, "R2 beat", issue_beat_o, m_beat);
      chk(issue_lanes_o == m_mask[m_beat*8 +: 8], "R3 lanes",
          issue_lanes_o, m_mask[m_beat*8 +: 8]);
      chk(issue_pc_o == m_pc[m_cur], "R5/R6/R8 pc", issue_pc_o, m_pc[m_cur]);
    end else begin
      chk(issue_lanes_o == 8'h00, "R7 lanes idle", issue_lanes_o, 0);
    end
  endtask

  task automatic model_edge();
    bit sel, fin;
    int found;
    sel = !m_busy || m_beat == 3;
    fin = m_busy && m_beat == 3;
    for (int w = 0; w < NW; w++)
      if ((fin && w == m_cur) || (sel && ready_i[w] && mw(w) == 0))
        m_pc[w] += 4;
    if (sel) begin
      found = -1;
      for (int i = 1; i <= NW; i++) begin
        int c;
        c = (m_last + i) % NW;
        if (found < 0 && ready_i[c] && mw(c) != 0) found = c;
      end
      m_beat = 0;
      if (found >= 0) begin
        m_busy = 1; m_cur = found; m_last = found; m_mask = mw(found);
      end else m_busy = 0;
    end else m_beat++;
  endtask

  // mode: 0 random, 1 sparse ready, 2 many empty masks, 3 all off, 4 all full
  task automatic run(input int cycles, input int mode);
    for (int c = 0; c < cycles; c++) begin
      step();
      for (int w = 0; w < NW; w++) begin
        logic [31:0] m;
        m = $urandom;
        case (mode)
          0: begin ready_i[w] = $urandom_range(0, 1); end
          1: begin ready_i[w] = ($urandom_range(0, 7) == 0); end
          2: begin ready_i[w] = $urandom_range(0, 1);
                   if ($urandom_range(0, 1) == 0) m = '0; end
          3: begin ready_i[w] = 1'b0; end
          default: begin ready_i[w] = 1'b1; m = '1; end
        endcase
        if (mode == 0 && $urandom_range(0, 3) == 0) m = m & 32'h00FF_0F00;
        mask_i[w*TH +: TH] = m;
      end
      model_edge();
    end
  endtask

  initial begin
    for (int w = 0; w < NW; w++) m_pc[w] = '0;
    m_busy = 0; m_cur = 0; m_beat = 0; m_last = NW - 1; m_mask = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state
    step();
    chk(issue_valid_o == 1'b0, "R1 reset valid", issue_valid_o, 0);
    model_edge();
    run(200, 4);   // R4 ascending rotation, R5 PC steps
    run(60, 3);    // R7 idle
    run(1500, 0);
    run(800, 1);
    run(1500, 2);  // R6 empty warps
    run(40, 3);
    run(400, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule